// File: doc/BRIEF.md
# Double-Buffered Piecewise-Linear Degamma Unit

This block linearizes three colour channels of a pixel stream. Each channel goes through one transfer curve. Five curves are available: a pass-through, two fixed power-law curves, and two programmable piecewise-linear curves. Each programmable curve sits in its own bank. A bank holds a point table, sixteen region descriptors and a pair of linear tails.

The host loads the bank that is not feeding the pixel path. It sets a point index, then streams six data words per point. The index advances by itself after each point. The host then queues a new mode. The queued mode reaches the pixel path on the next frame-start pulse, so one frame never mixes two curves. A status output reports which bank is live.

The curve input is a 16-bit unsigned code. The position of its leading one selects one of sixteen power-of-two regions. A descriptor splits that region into 2^n equal segments and points at the first table entry of the region. The output is the segment's base value plus its delta, scaled by the input's position inside the segment and rounded.

Top module: `degamma_pwl`

## Requirements
- R1: The queued mode code selects the curve: 0 passes the input through unchanged, 1 is the first fixed curve, 2 is the second fixed curve, 3 uses bank A, 4 uses bank B. A mode write of 5, 6 or 7 leaves the queued mode unchanged.
- R2: Mode 1 outputs floor(x*x / 65536).
- R3: Mode 2 outputs x/16 (floor) when x < 0x1000, and floor(x*x / 65536) otherwise.
- R4: `cfgStatus` reads 9 while bank A is live, 10 while bank B is live, and 0 in the other modes. It reads 0 out of reset.
- R5: A mode write (host address 0, bits [2:0]) takes effect only on a clock edge where `frameStart` is high. Before that edge, the output follows the previous mode.
- R6: A write to address 2 sets the point index from its low bits and restarts the word count. Each write to address 3 stores bits [15:0] as the next word. The words of a point come in this order: base red, base green, base blue, delta red, delta green, delta blue. After the sixth word the index moves to the next point and wraps at the table size.
- R7: Address 1 sets the load target: bit 0 picks the bank (0 = A, 1 = B), and bits [3:1] enable the red, green and blue channels. A word for a disabled channel leaves that channel's table entry unchanged.
- R8: While the load-target bank is live, the block ignores data words, descriptor writes and tail-parameter writes to it.
- R9: Addresses 4 to 11 each carry two descriptors. Region 2k is in bits [15:0] and region 2k+1 is in bits [31:16] of address 4+k. A descriptor holds a table offset in bits [7:0] and log2 of its segment count in bits [10:8]. The region of x is the bit position of its leading one, and region 0 is used for x = 0. The effective log2 count is min(n, region). The entry used is (offset + segment) modulo the table size.
- R10: Between the start and end points inclusive, the output is base + round(delta * low / 2^sh), where sh = region - effective log2 count, low is the lowest sh bits of x, and a half rounds up. The result saturates at 0xFFFF.
- R11: For x below the start point (address 12 bits [15:0]), the output is floor(x * slope / 256), where slope is address 12 bits [31:16]. The result saturates at 0xFFFF.
- R12: For x above the end point (address 13 bits [15:0]), the output is endBase + floor((x - end) * endSlope / 256). Address 14 holds endBase in bits [15:0] and endSlope in bits [31:16]. The result saturates at 0xFFFF.
- R13: `outValid` and `pixOut` follow a sampled `pixValid` after exactly two clock edges, and `outValid` is low out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Frame boundary pulse; applies the queued mode |
| hostWr | input | 1 | Host register write strobe |
| hostAddr | input | 4 | Host register address |
| hostData | input | 32 | Host write data |
| pixValid | input | 1 | Input pixel valid |
| pixIn | input | 48 | Three 16-bit channels: red [15:0], green [31:16], blue [47:32] |
| outValid | output | 1 | Output pixel valid |
| pixOut | output | 48 | Linearized channels, same packing as the input |
| cfgStatus | output | 4 | Live-bank status code |

## Verification
The hardest case to reach is a load aimed at the live bank. To reach it, the stimulus activates bank A and leaves the load target on A. It then streams a full point, a descriptor and a tail parameter that all hit the entry and region used by one chosen input code. Finally it sends that code and checks that the output still matches the original curve. A partly masked load is reached the same way. The bench computes which table entry a chosen code selects, rewrites only the red channel of that entry in the idle bank, and checks that only red changes once that bank goes live.

// File: rtl/dgm_pkg.sv
package dgm_pkg;
  localparam int PIX_W      = 16;
  localparam int NUM_CH     = 3;
  localparam int NUM_RGN    = PIX_W;
  localparam int RGN_W      = $clog2(NUM_RGN);
  localparam int SEG_W      = 3;
  localparam int OFF_W      = 8;
  localparam int SLOPE_FRAC = 8;
  localparam int HOST_W     = 32;
  localparam int ADDR_W     = 4;
  localparam logic [PIX_W-1:0] XV_KNEE = 16'h1000;

  localparam logic [ADDR_W-1:0] A_MODE  = 4'd0;
  localparam logic [ADDR_W-1:0] A_LOAD  = 4'd1;
  localparam logic [ADDR_W-1:0] A_INDEX = 4'd2;
  localparam logic [ADDR_W-1:0] A_DATA  = 4'd3;
  localparam logic [ADDR_W-1:0] A_RGN0  = 4'd4;
  localparam logic [ADDR_W-1:0] A_START = 4'd12;
  localparam logic [ADDR_W-1:0] A_ENDX  = 4'd13;
  localparam logic [ADDR_W-1:0] A_END   = 4'd14;

  typedef enum logic [2:0] {
    MODE_BYPASS = 3'd0,
    MODE_SRGB   = 3'd1,
    MODE_XVYCC  = 3'd2,
    MODE_RAMA   = 3'd3,
    MODE_RAMB   = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    K_PASS, K_LOW, K_HIGH, K_INTERP
  } kind_e;

  typedef struct packed {
    logic [SEG_W-1:0] segLog2;
    logic [OFF_W-1:0] offset;
  } regDesc_t;

  typedef struct packed {
    logic [PIX_W-1:0] startX;
    logic [PIX_W-1:0] startSlope;
    logic [PIX_W-1:0] endX;
    logic [PIX_W-1:0] endBase;
    logic [PIX_W-1:0] endSlope;
    regDesc_t [NUM_RGN-1:0] desc;
  } curveCfg_t;

  // Strobes from control to datapath for one table word.
  typedef struct packed {
    logic              wrPoint;
    logic              wrBank;
    logic              wrDelta;
    logic [NUM_CH-1:0] wrMask;
    logic [PIX_W-1:0]  wrData;
  } wrStrb_t;
endpackage

// File: rtl/dgm_ctrl.sv
module dgm_ctrl
  import dgm_pkg::*;
#(
  parameter int POINTS = 64,
  localparam int IDX_W = $clog2(POINTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [HOST_W-1:0] hostData,
  output mode_e             activeMode,
  output curveCfg_t         useCfg,
  output wrStrb_t           strb,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [3:0]        cfgStatus
);
  mode_e             pendMode;
  logic              loadBank;
  logic [NUM_CH-1:0] loadMask;
  logic [IDX_W-1:0]  ptIdx;
  logic [2:0]        wordCnt;
  curveCfg_t         cfgBank [2];

  logic       tgtBusy;
  logic       isRegion;
  logic [2:0] rgnPair;
  logic [1:0] wordCh;

  assign tgtBusy  = (activeMode == MODE_RAMA && !loadBank) ||
                    (activeMode == MODE_RAMB &&  loadBank);
  assign isRegion = (hostAddr >= A_RGN0) && (hostAddr <= A_RGN0 + 4'd7);
  assign rgnPair  = 3'(hostAddr - A_RGN0);
  assign wordCh   = (wordCnt >= 3'd3) ? 2'(wordCnt - 3'd3) : 2'(wordCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMode   <= MODE_BYPASS;
      activeMode <= MODE_BYPASS;
      loadBank   <= 1'b0;
      loadMask   <= '1;
      ptIdx      <= '0;
      wordCnt    <= '0;
      cfgBank[0] <= '0;
      cfgBank[1] <= '0;
    end else begin
      if (frameStart) activeMode <= pendMode;
      if (hostWr) begin
        if (hostAddr == A_MODE) begin
          if (hostData[2:0] <= 3'd4) pendMode <= mode_e'(hostData[2:0]);
        end else if (hostAddr == A_LOAD) begin
          loadBank <= hostData[0];
          loadMask <= hostData[NUM_CH:1];
        end else if (hostAddr == A_INDEX) begin
          ptIdx   <= hostData[IDX_W-1:0];
          wordCnt <= '0;
        end else if (!tgtBusy) begin
          if (hostAddr == A_DATA) begin
            if (wordCnt == 3'd5) begin
              wordCnt <= '0;
              ptIdx   <= (ptIdx == IDX_W'(POINTS - 1)) ? '0 : ptIdx + 1'b1;
            end else begin
              wordCnt <= wordCnt + 3'd1;
            end
          end else if (isRegion) begin
            cfgBank[loadBank].desc[{rgnPair, 1'b0}] <= regDesc_t'({hostData[10:8], hostData[7:0]});
            cfgBank[loadBank].desc[{rgnPair, 1'b1}] <= regDesc_t'({hostData[26:24], hostData[23:16]});
          end else if (hostAddr == A_START) begin
            cfgBank[loadBank].startX     <= hostData[15:0];
            cfgBank[loadBank].startSlope <= hostData[31:16];
          end else if (hostAddr == A_ENDX) begin
            cfgBank[loadBank].endX <= hostData[15:0];
          end else if (hostAddr == A_END) begin
            cfgBank[loadBank].endBase  <= hostData[15:0];
            cfgBank[loadBank].endSlope <= hostData[31:16];
          end
        end
      end
    end
  end

  always_comb begin
    strb.wrPoint = hostWr && (hostAddr == A_DATA) && !tgtBusy;
    strb.wrBank  = loadBank;
    strb.wrDelta = (wordCnt >= 3'd3);
    strb.wrMask  = loadMask & (NUM_CH'(1) << wordCh);
    strb.wrData  = hostData[PIX_W-1:0];
  end

  assign wrIdx  = ptIdx;
  assign useCfg = cfgBank[activeMode == MODE_RAMB];

  always_comb begin
    case (activeMode)
      MODE_RAMA: cfgStatus = 4'd9;
      MODE_RAMB: cfgStatus = 4'd10;
      default:   cfgStatus = 4'd0;
    endcase
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(activeMode)) else $error("mode changed off frame"); // R5
  AST_NO_LIVE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPoint |-> (cfgStatus != (strb.wrBank ? 4'd10 : 4'd9))) else $error("write to live bank"); // R8
  AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wordCnt <= 3'd5) else $error("word counter overrun"); // R6
endmodule

// File: rtl/dgm_dpath.sv
module dgm_dpath
  import dgm_pkg::*;
#(
  parameter int POINTS = 64,
  localparam int IDX_W = $clog2(POINTS),
  localparam int SQ_W  = 2 * PIX_W,
  localparam int ACC_W = 3 * PIX_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mode_e                   activeMode,
  input  curveCfg_t               useCfg,
  input  wrStrb_t                 strb,
  input  logic [IDX_W-1:0]        wrIdx,
  input  logic                    pixValid,
  input  logic [NUM_CH*PIX_W-1:0] pixIn,
  output logic                    outValid,
  output logic [NUM_CH*PIX_W-1:0] pixOut
);
  logic [PIX_W-1:0] baseMem  [2][NUM_CH][POINTS];
  logic [PIX_W-1:0] deltaMem [2][NUM_CH][POINTS];

  always_ff @(posedge clk) begin
    if (strb.wrPoint) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (strb.wrMask[c]) begin
          if (strb.wrDelta) deltaMem[strb.wrBank][c][wrIdx] <= strb.wrData;
          else              baseMem[strb.wrBank][c][wrIdx]  <= strb.wrData;
        end
      end
    end
  end

  logic             s1Valid;
  logic [PIX_W-1:0] s1Slope, s1EndX, s1EndBase, s1EndSlope;
  logic             bankSel;
  assign bankSel = (activeMode == MODE_RAMB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid    <= 1'b0;
      outValid   <= 1'b0;
      s1Slope    <= '0;
      s1EndX     <= '0;
      s1EndBase  <= '0;
      s1EndSlope <= '0;
    end else begin
      s1Valid    <= pixValid;
      outValid   <= s1Valid;
      s1Slope    <= useCfg.startSlope;
      s1EndX     <= useCfg.endX;
      s1EndBase  <= useCfg.endBase;
      s1EndSlope <= useCfg.endSlope;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [PIX_W-1:0] x, segIdx, low, passVal;
    logic [RGN_W-1:0] rgn, segEff, sh;
    regDesc_t         d;
    logic [IDX_W-1:0] addr;
    kind_e            kind;

    always_comb begin
      x   = pixIn[g*PIX_W +: PIX_W];
      rgn = '0;
      for (int i = 0; i < PIX_W; i++) if (x[i]) rgn = RGN_W'(i);
      d      = useCfg.desc[rgn];
      segEff = (RGN_W'(d.segLog2) > rgn) ? rgn : RGN_W'(d.segLog2);
      sh     = rgn - segEff;
      segIdx = (x & ~(PIX_W'(1) << rgn)) >> sh;
      low    = x & ((PIX_W'(1) << sh) - PIX_W'(1));
      addr   = IDX_W'(PIX_W'(d.offset) + segIdx);
      case (activeMode)
        MODE_SRGB:  passVal = PIX_W'((SQ_W'(x) * SQ_W'(x)) >> PIX_W);
        MODE_XVYCC: passVal = (x < XV_KNEE) ? (x >> 4) : PIX_W'((SQ_W'(x) * SQ_W'(x)) >> PIX_W);
        default:    passVal = x;
      endcase
      if (activeMode == MODE_RAMA || activeMode == MODE_RAMB) begin
        if (x < useCfg.startX)     kind = K_LOW;
        else if (x > useCfg.endX)  kind = K_HIGH;
        else                       kind = K_INTERP;
      end else begin
        kind = K_PASS;
      end
    end

    kind_e            s1Kind;
    logic [PIX_W-1:0] s1X, s1Pass, s1Base, s1Delta, s1Low;
    logic [RGN_W-1:0] s1Sh;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s1Kind  <= K_PASS;
        s1X     <= '0;
        s1Pass  <= '0;
        s1Base  <= '0;
        s1Delta <= '0;
        s1Low   <= '0;
        s1Sh    <= '0;
      end else begin
        s1Kind  <= kind;
        s1X     <= x;
        s1Pass  <= passVal;
        s1Base  <= baseMem[bankSel][g][addr];
        s1Delta <= deltaMem[bankSel][g][addr];
        s1Low   <= low;
        s1Sh    <= sh;
      end
    end

    logic [ACC_W-1:0] acc, rnd;
    logic [PIX_W-1:0] satVal, outReg;

    always_comb begin
      rnd = (s1Sh == '0) ? '0 : (ACC_W'(1) << (s1Sh - RGN_W'(1)));
      case (s1Kind)
        K_LOW:    acc = (ACC_W'(s1X) * ACC_W'(s1Slope)) >> SLOPE_FRAC;
        K_HIGH:   acc = ACC_W'(s1EndBase) +
                        ((ACC_W'(s1X - s1EndX) * ACC_W'(s1EndSlope)) >> SLOPE_FRAC);
        K_INTERP: acc = ACC_W'(s1Base) + ((ACC_W'(s1Delta) * ACC_W'(s1Low) + rnd) >> s1Sh);
        default:  acc = ACC_W'(s1Pass);
      endcase
      satVal = (acc > ACC_W'({PIX_W{1'b1}})) ? {PIX_W{1'b1}} : acc[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outReg <= '0;
      else       outReg <= satVal;
    end

    assign pixOut[g*PIX_W +: PIX_W] = outReg;
  end

  AST_PIPE_S1: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> s1Valid) else $error("stage one valid lost"); // R13
  AST_PIPE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |=> outValid) else $error("output valid lost"); // R13
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !s1Valid |=> !outValid) else $error("spurious output valid"); // R13
endmodule

// File: rtl/degamma_pwl.sv
module degamma_pwl
  import dgm_pkg::*;
#(
  parameter int POINTS = 64,
  localparam int IDX_W = $clog2(POINTS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameStart,
  input  logic                    hostWr,
  input  logic [ADDR_W-1:0]       hostAddr,
  input  logic [HOST_W-1:0]       hostData,
  input  logic                    pixValid,
  input  logic [NUM_CH*PIX_W-1:0] pixIn,
  output logic                    outValid,
  output logic [NUM_CH*PIX_W-1:0] pixOut,
  output logic [3:0]              cfgStatus
);
  mode_e            activeMode;
  curveCfg_t        useCfg;
  wrStrb_t          strb;
  logic [IDX_W-1:0] wrIdx;

  dgm_ctrl #(.POINTS(POINTS)) uCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .hostWr(hostWr), .hostAddr(hostAddr), .hostData(hostData),
    .activeMode(activeMode), .useCfg(useCfg), .strb(strb),
    .wrIdx(wrIdx), .cfgStatus(cfgStatus)
  );

  dgm_dpath #(.POINTS(POINTS)) uDpath (
    .clk(clk), .rstN(rstN), .activeMode(activeMode), .useCfg(useCfg),
    .strb(strb), .wrIdx(wrIdx), .pixValid(pixValid), .pixIn(pixIn),
    .outValid(outValid), .pixOut(pixOut)
  );
endmodule

// File: tb/sim_degamma_pwl.sv
module sim_degamma_pwl;
  localparam int PTS = 64;

  logic        clk = 1'b0;
  logic        rstN, frameStart, hostWr, pixValid;
  logic [3:0]  hostAddr;
  logic [31:0] hostData;
  logic [47:0] pixIn;
  wire         outValid;
  wire  [47:0] pixOut;
  wire  [3:0]  cfgStatus;

  always #2 clk = ~clk;

  degamma_pwl #(.POINTS(PTS)) u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostData(hostData), .pixValid(pixValid),
    .pixIn(pixIn), .outValid(outValid), .pixOut(pixOut), .cfgStatus(cfgStatus)
  );

  int nChecks = 0, nFails = 0;
  bit done = 0;
  int curMode;
  int mBase[2][3][PTS], mDelta[2][3][PTS];
  int mOff[2][16], mSeg[2][16];
  int mSX[2], mSS[2], mEX[2], mEB[2], mES[2];

  task automatic check(string tag, longint got, longint exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic hostWrite(int a, longint d);
    @(negedge clk);
    hostWr = 1; hostAddr = 4'(a); hostData = d[31:0];
    @(negedge clk);
    hostWr = 0;
  endtask

  task automatic frame();
    @(negedge clk); frameStart = 1;
    @(negedge clk); frameStart = 0;
  endtask

  function automatic int msbOf(int x);
    int r = 0;
    for (int i = 0; i < 16; i++) if (x[i]) r = i;
    return r;
  endfunction

  function automatic int shOf(int b, int x);
    int r = msbOf(x);
    int s = (mSeg[b][r] > r) ? r : mSeg[b][r];
    return r - s;
  endfunction

  function automatic int ptOf(int b, int x);
    int r = msbOf(x);
    int seg = (x - ((x == 0) ? 0 : (1 << r))) >> shOf(b, x);
    return (mOff[b][r] + seg) % PTS;
  endfunction

  function automatic longint sat(longint v);
    return (v > 65535) ? 65535 : v;
  endfunction

  function automatic longint expRam(int b, int ch, int x);
    longint v;
    if (x < mSX[b]) v = (longint'(x) * mSS[b]) >> 8;
    else if (x > mEX[b]) v = mEB[b] + ((longint'(x - mEX[b]) * mES[b]) >> 8);
    else begin
      int sh = shOf(b, x);
      int p = ptOf(b, x);
      longint lowv = x & ((1 << sh) - 1);
      longint rnd = (sh == 0) ? 0 : (longint'(1) << (sh - 1));
      v = mBase[b][ch][p] + ((longint'(mDelta[b][ch][p]) * lowv + rnd) >> sh);
    end
    return sat(v);
  endfunction

  function automatic longint expChan(int ch, int x);
    case (curMode)
      1: return (longint'(x) * x) >> 16;
      2: return (x < 'h1000) ? (x >> 4) : ((longint'(x) * x) >> 16);
      3: return expRam(0, ch, x);
      4: return expRam(1, ch, x);
      default: return x;
    endcase
  endfunction

  function automatic string zoneTag(int x);
    int b = (curMode == 4) ? 1 : 0;
    if (curMode < 3) return (curMode == 0) ? "R1" : ((curMode == 1) ? "R2" : "R3");
    if (x < mSX[b]) return "R11";
    if (x > mEX[b]) return "R12";
    return "R9/R10/R6";
  endfunction

  task automatic pixel(int x0, int x1, int x2, string tag);
    int xs[3];
    xs[0] = x0; xs[1] = x1; xs[2] = x2;
    @(negedge clk);
    pixIn = {16'(x2), 16'(x1), 16'(x0)}; pixValid = 1;
    @(negedge clk);
    pixValid = 0;
    @(negedge clk);
    check("R13 outValid", outValid, 1);
    for (int c = 0; c < 3; c++)
      check((tag == "") ? zoneTag(xs[c]) : tag, pixOut[c*16 +: 16], expChan(c, xs[c]));
  endtask

  task automatic randPix(int n);
    for (int i = 0; i < n; i++)
      pixel($urandom_range(0, 65535), $urandom_range(0, 65535), $urandom_range(0, 65535), "");
  endtask

  task automatic progBank(int b);
    hostWrite(1, (7 << 1) | b);
    for (int r = 0; r < 16; r++) begin
      mSeg[b][r] = $urandom_range(0, 7);
      mOff[b][r] = $urandom_range(0, 255);
    end
    for (int k = 0; k < 8; k++)
      hostWrite(4 + k, (longint'((mSeg[b][2*k+1] << 8) | mOff[b][2*k+1]) << 16) |
                        ((mSeg[b][2*k] << 8) | mOff[b][2*k]));
    mSX[b] = $urandom_range(1, 'h300); mSS[b] = $urandom_range(0, 65535);
    mEX[b] = $urandom_range('hC000, 'hFFF0);
    mEB[b] = $urandom_range(0, 65535); mES[b] = $urandom_range(0, 'hFFF);
    hostWrite(12, (longint'(mSS[b]) << 16) | mSX[b]);
    hostWrite(13, mEX[b]);
    hostWrite(14, (longint'(mES[b]) << 16) | mEB[b]);
    hostWrite(2, 0);
    for (int p = 0; p < PTS; p++) begin
      for (int c = 0; c < 3; c++) mBase[b][c][p] = $urandom_range(0, 65535);
      for (int c = 0; c < 3; c++) mDelta[b][c][p] = (p % 8 == 0) ? 'hFFFF : $urandom_range(0, 'h3FFF);
      for (int c = 0; c < 3; c++) hostWrite(3, mBase[b][c][p]);
      for (int c = 0; c < 3; c++) hostWrite(3, mDelta[b][c][p]);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog R13: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int xT, idx;
    rstN = 0; frameStart = 0; hostWr = 0; hostAddr = 0; hostData = 0;
    pixValid = 0; pixIn = 0; curMode = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R4 reset status", cfgStatus, 0);
    check("R13 reset valid", outValid, 0);
    rstN = 1;

    // R1 bypass
    randPix(15);
    pixel(0, 65535, 'h8000, "R1");
    repeat (3) @(negedge clk);
    check("R13 idle valid", outValid, 0);

    // R5 queued mode waits for frame
    hostWrite(0, 1);
    pixel('h1234, 'hFFFF, 'h0100, "R5");
    frame(); curMode = 1;
    randPix(15);
    pixel(0, 65535, 1, "R2");

    hostWrite(0, 2); frame(); curMode = 2;
    pixel('h0FFF, 'h1000, 0, "R3");
    pixel('h0010, 'h1001, 65535, "R3");
    randPix(15);
    check("R4 fixed status", cfgStatus, 0);

    // R1 illegal mode code leaves queued mode
    hostWrite(0, 7); frame();
    pixel('h0800, 'h2000, 'hABCD, "R1");

    progBank(0);
    progBank(1);

    // R7 masked rewrite of red in bank B at the entry used by xT
    xT = 'h2345;
    idx = ptOf(1, xT);
    hostWrite(1, (1 << 1) | 1);
    hostWrite(2, idx);
    mBase[1][0][idx] = 'h0111; mDelta[1][0][idx] = 'h0022;
    hostWrite(3, 'h0111); hostWrite(3, 'h5555); hostWrite(3, 'h6666);
    hostWrite(3, 'h0022); hostWrite(3, 'h7777); hostWrite(3, 'h8888);

    hostWrite(0, 3); frame(); curMode = 3;
    check("R4 bank A status", cfgStatus, 9);
    randPix(60);
    // R9 directed region edges and tails
    pixel(mSX[0] - 1, mSX[0], mEX[0], "");
    pixel(mEX[0] + 1, 0, 65535, "");
    pixel(1, 2, 3, "");
    pixel(xT, 'h8000, 'h7FFF, "");

    // R8 writes aimed at the live bank are dropped
    hostWrite(1, (7 << 1) | 0);
    hostWrite(2, ptOf(0, xT));
    for (int k = 0; k < 6; k++) hostWrite(3, 'hFFFF);
    hostWrite(4 + msbOf(xT) / 2, 'h07FF07FF);
    hostWrite(12, 'hFFFFFFFF);
    hostWrite(14, 'h00000000);
    pixel(xT, xT, xT, "R8");
    pixel(0, mSX[0] - 1, 65535, "R8");
    for (int i = 0; i < 10; i++)
      pixel($urandom_range(0, 65535), $urandom_range(0, 65535), $urandom_range(0, 65535), "R8");

    hostWrite(0, 4); frame(); curMode = 4;
    check("R4 bank B status", cfgStatus, 10);
    pixel(xT, xT, xT, "R7");
    randPix(60);
    pixel(mSX[1] - 1, mSX[1], mEX[1] + 1, "");

    hostWrite(0, 0); frame(); curMode = 0;
    check("R4 bypass status", cfgStatus, 0);
    pixel('h4321, 'h0001, 'hFFFE, "R1");

    done = 1;
    summary();
    $finish;
  end
endmodule